// File: doc/BRIEF.md
# Receive Error Manager with Three-Entry Byte FIFO

This block sits on the receive side of a byte-synchronous serial controller, between the deserializer and the memory-side consumer. Bytes arrive on a strobe with a per-byte parity-error flag. They are held in a small FIFO whose head, with its parity flag, is offered to the consumer. The consumer removes the head with a pop. The block watches for three error conditions during a message: carrier loss, FIFO overrun and parity error. When one occurs it closes the current buffer. Closing reports a single status bit, raises the receive interrupt when that is enabled, and returns the receiver to hunt mode.

A small state machine runs the block. It has three states. HUNT ignores incoming bytes until the sync detector reports `sync_hit`, and the transition HUNT→RECV is taken on that input. RECV writes bytes into the FIFO and checks for errors. On any error, RECV→CLOSE is taken. CLOSE lasts one cycle, presents the close strobe and the interrupt, and always takes CLOSE→HUNT. After a carrier loss the FIFO is flushed. After an overrun or a parity error the entries already held stay available to drain.

Top module: `rx_err_mgr`

## Requirements
- R1: After reset, `hunting` is 1, `fifo_vld` is 0, `fifo_level` is 0, and `close_stb`, `rx_irq`, `st_ov`, `st_cd` and `st_pr` are all 0.
- R2: While `hunting` is 1, `byte_vld` writes nothing into the FIFO. A `sync_hit` in HUNT makes `hunting` 0 from the next cycle.
- R3: In RECV, up to three accepted bytes are returned in arrival order. `fifo_data` and `fifo_par_err` show the oldest entry. `fifo_level` counts the entries. A pop removes the head one cycle later.
- R4: A byte that arrives while the FIFO is full, in the same cycle as a pop, is accepted normally. It raises no error and leaves `fifo_level` at 3.
- R5: A byte that arrives while the FIFO holds three entries, with no pop, replaces the newest entry, including that entry's parity flag. `fifo_level` stays 3, and the buffer closes with `st_ov`.
- R6: In RECV with `cd_sw_ctl` at 0, `carrier_ok` at 0 closes the buffer with `st_cd`. The FIFO is flushed to level 0, and a byte offered in that cycle is discarded.
- R7: With `cd_sw_ctl` at 1, `carrier_ok` has no effect: bytes are still accepted and no close occurs.
- R8: A byte with its parity-error flag set is still written to the FIFO with `fifo_par_err` at 1, and the buffer closes with `st_pr`.
- R9: When several errors occur in one cycle, only one status bit is set, by the priority carrier loss, then overrun, then parity.
- R10: `close_stb` is high for exactly the one cycle after the cycle in which the error was seen, and `hunting` is 1 in the cycle after that. Bytes offered during that close cycle are ignored. The status bits hold their values until the next close.
- R11: `rx_irq` is high during the close cycle only when `irq_en` is 1. With `irq_en` at 0 the status bits are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| byte_par_err | input | 1 | Parity error flag of the received byte |
| sync_hit | input | 1 | Sync found by the hunter; leaves HUNT |
| carrier_ok | input | 1 | Carrier detect, 1 = carrier present |
| cd_sw_ctl | input | 1 | 1 = carrier line handled by software, ignored here |
| irq_en | input | 1 | Receive interrupt enable |
| fifo_pop | input | 1 | Consumer removes the FIFO head |
| fifo_vld | output | 1 | FIFO holds at least one entry |
| fifo_data | output | 8 | Byte at the FIFO head |
| fifo_par_err | output | 1 | Parity flag of the FIFO head |
| fifo_level | output | 2 | Number of entries held |
| close_stb | output | 1 | Buffer close strobe (CLOSE state) |
| st_ov | output | 1 | Close status: overrun |
| st_cd | output | 1 | Close status: carrier lost |
| st_pr | output | 1 | Close status: parity error |
| rx_irq | output | 1 | Receive interrupt |
| hunting | output | 1 | Receiver is in hunt mode |

## Verification
A wrong FSM state shows on `hunting` and `close_stb` one cycle after the input that should have moved it. For example, if the machine stays in RECV after a close, `hunting` stays low and the FIFO level keeps rising on later bytes. A wrong FIFO pointer or count shows on `fifo_level` at once, and on `fifo_data` when the entries are drained. An overwrite of the wrong slot appears only when the third entry reaches the head. A wrong priority selection shows as more than one status bit, or the wrong one, during the close cycle. After a carrier loss it also shows as a non-zero level.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_RECV  = 2'd1,
        ST_CLOSE = 2'd2
    } rxe_state_t;

    // error set, most urgent in the top bit
    typedef struct packed {
        logic cd;
        logic ov;
        logic pr;
    } rxe_err_t;

    localparam int ERR_W = 3;

endpackage

// File: rtl/rxe_err_pri.sv
module rxe_err_pri
    import rxe_pkg::*;
(
    input  rxe_err_t raw,
    output rxe_err_t sel,
    output logic     any
);

    logic [ERR_W-1:0] raw_v;
    logic [ERR_W-1:0] sel_v;

    assign raw_v = raw;

    // keep only the highest set bit
    always_comb begin
        sel_v = '0;
        for (int i = ERR_W - 1; i >= 0; i--) begin
            if (raw_v[i] && (sel_v == '0)) begin
                sel_v[i] = 1'b1;
            end
        end
    end

    assign sel = sel_v;
    assign any = |raw_v;

endmodule

// File: rtl/rxe_fifo.sv
module rxe_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         ovwr,
    input  logic                         pop,
    input  logic                         flush,
    input  logic [WIDTH-1:0]             din,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr, last_ptr;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == LW'(DEPTH));
    assign do_pop   = pop && !empty && !flush;
    assign do_push  = push && (!full || do_pop) && !flush;
    assign last_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end else if (ovwr && !flush && !empty) begin
            mem[last_ptr] <= din;
        end
    end

    assign dout  = mem[rd_ptr];
    assign level = cnt;

endmodule

// File: rtl/rx_err_mgr.sv
module rx_err_mgr
    import rxe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_par_err,
    input  logic              sync_hit,
    input  logic              carrier_ok,
    input  logic              cd_sw_ctl,
    input  logic              irq_en,
    input  logic              fifo_pop,
    output logic              fifo_vld,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_par_err,
    output logic [LW-1:0]     fifo_level,
    output logic              close_stb,
    output logic              st_ov,
    output logic              st_cd,
    output logic              st_pr,
    output logic              rx_irq,
    output logic              hunting
);

    localparam int EW = DATA_W + 1;

    rxe_state_t    state, state_nx;
    rxe_err_t      raw_err, sel_err;
    logic          err_any;
    logic          in_recv;
    logic          f_push, f_empty, f_full;
    logic [EW-1:0] f_din, f_dout;

    assign in_recv = (state == ST_RECV);

    // error detection, only meaningful while receiving
    assign raw_err.cd = in_recv && !carrier_ok && !cd_sw_ctl;
    assign raw_err.ov = in_recv && byte_vld && f_full && !fifo_pop;
    assign raw_err.pr = in_recv && byte_vld && byte_par_err;

    rxe_err_pri u_pri (
        .raw (raw_err),
        .sel (sel_err),
        .any (err_any)
    );

    assign f_push = in_recv && byte_vld && !raw_err.cd && !raw_err.ov;
    assign f_din  = {byte_par_err, byte_data};

    rxe_fifo #(
        .WIDTH (EW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .ovwr  (sel_err.ov),
        .pop   (fifo_pop),
        .flush (sel_err.cd),
        .din   (f_din),
        .dout  (f_dout),
        .level (fifo_level),
        .empty (f_empty),
        .full  (f_full)
    );

    // state register and close status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            st_cd <= 1'b0;
            st_ov <= 1'b0;
            st_pr <= 1'b0;
        end else begin
            state <= state_nx;
            if (err_any) begin
                st_cd <= sel_err.cd;
                st_ov <= sel_err.ov;
                st_pr <= sel_err.pr;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (sync_hit) state_nx = ST_RECV;
            ST_RECV:  if (err_any)  state_nx = ST_CLOSE;
            ST_CLOSE: state_nx = ST_HUNT;
            default:  state_nx = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        hunting   = 1'b0;
        close_stb = 1'b0;
        unique case (state)
            ST_HUNT:  hunting   = 1'b1;
            ST_RECV:  ;
            ST_CLOSE: close_stb = 1'b1;
            default:  hunting   = 1'b1;
        endcase
        rx_irq = close_stb && irq_en;
    end

    assign fifo_vld     = !f_empty;
    assign fifo_data    = f_dout[DATA_W-1:0];
    assign fifo_par_err = f_dout[DATA_W];

endmodule

// File: rtl/rx_err_mgr_chk.sv
module rx_err_mgr_chk #(
    parameter int DEPTH = 3,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_vld,
    input logic [LW-1:0] fifo_level,
    input logic          close_stb,
    input logic          st_ov,
    input logic          st_cd,
    input logic          st_pr,
    input logic          hunting
);

    // R9: one status bit at most
    p_status_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_cd, st_ov, st_pr}));

    // R3: level never passes the depth, valid tracks level
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level <= LW'(DEPTH)) && (fifo_vld == (fifo_level != '0)));

    // R2: nothing enters the FIFO while hunting
    p_hunt_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |=> (fifo_level <= $past(fifo_level)));

    // R10: one-cycle close, then hunt
    p_close_then_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        close_stb |=> (hunting && !close_stb));

    // R6: carrier loss empties the FIFO
    p_cd_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (close_stb && st_cd) |-> (fifo_level == '0));

    // R5: overrun keeps a full FIFO
    p_ov_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (close_stb && st_ov) |-> (fifo_level == LW'(DEPTH)));

endmodule

bind rx_err_mgr rx_err_mgr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_vld   (fifo_vld),
    .fifo_level (fifo_level),
    .close_stb  (close_stb),
    .st_ov      (st_ov),
    .st_cd      (st_cd),
    .st_pr      (st_pr),
    .hunting    (hunting)
);

// File: tb/rx_err_mgr_tb.sv
`timescale 1ns/1ps
module rx_err_mgr_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_par_err = 1'b0;
    logic       sync_hit = 1'b0;
    logic       carrier_ok = 1'b1;
    logic       cd_sw_ctl = 1'b0;
    logic       irq_en = 1'b1;
    logic       fifo_pop = 1'b0;
    logic       fifo_vld;
    logic [7:0] fifo_data;
    logic       fifo_par_err;
    logic [1:0] fifo_level;
    logic       close_stb, st_ov, st_cd, st_pr, rx_irq, hunting;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_err_mgr u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .byte_par_err (byte_par_err),
        .sync_hit     (sync_hit),
        .carrier_ok   (carrier_ok),
        .cd_sw_ctl    (cd_sw_ctl),
        .irq_en       (irq_en),
        .fifo_pop     (fifo_pop),
        .fifo_vld     (fifo_vld),
        .fifo_data    (fifo_data),
        .fifo_par_err (fifo_par_err),
        .fifo_level   (fifo_level),
        .close_stb    (close_stb),
        .st_ov        (st_ov),
        .st_cd        (st_cd),
        .st_pr        (st_pr),
        .rx_irq       (rx_irq),
        .hunting      (hunting)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // inputs change and outputs are sampled at the falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic par, input logic pop);
        byte_vld = 1'b1; byte_data = d; byte_par_err = par; fifo_pop = pop;
        step();
        byte_vld = 1'b0; byte_par_err = 1'b0; fifo_pop = 1'b0;
    endtask

    task automatic sync();
        sync_hit = 1'b1;
        step();
        sync_hit = 1'b0;
    endtask

    task automatic drain(input string tag, input logic [7:0] d, input logic par);
        chk({tag, " head data"}, fifo_data, d);
        chk({tag, " head parity"}, fifo_par_err, par);
        fifo_pop = 1'b1;
        step();
        fifo_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 hunting", hunting, 1);
        chk("R1 fifo_vld", fifo_vld, 0);
        chk("R1 level", fifo_level, 0);
        chk("R1 status", {close_stb, rx_irq, st_ov, st_cd, st_pr}, 0);
    endtask

    task automatic t_hunt();
        push(8'h99, 1'b0, 1'b0);
        chk("R2 byte ignored in hunt", fifo_level, 0);
        sync();
        chk("R2 sync leaves hunt", hunting, 0);
    endtask

    task automatic t_order();
        push(8'hA1, 1'b0, 1'b0);
        push(8'hA2, 1'b0, 1'b0);
        push(8'hA3, 1'b0, 1'b0);
        chk("R3 level three", fifo_level, 3);
        chk("R3 no close", close_stb, 0);
        push(8'hA4, 1'b0, 1'b1);
        chk("R4 push with pop when full level", fifo_level, 3);
        chk("R4 no close", close_stb, 0);
        drain("R3", 8'hA2, 1'b0);
        drain("R3", 8'hA3, 1'b0);
        drain("R4", 8'hA4, 1'b0);
        chk("R3 empty after drain", fifo_vld, 0);
    endtask

    task automatic t_cd();
        irq_en = 1'b0;
        push(8'h11, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b0);
        carrier_ok = 1'b0;
        push(8'h33, 1'b1, 1'b0);
        carrier_ok = 1'b1;
        chk("R6 close", close_stb, 1);
        chk("R6 cd status", st_cd, 1);
        chk("R9 cd over parity", {st_ov, st_pr}, 0);
        chk("R6 flushed", fifo_level, 0);
        chk("R11 irq masked", rx_irq, 0);
        step();
        chk("R10 back to hunt", hunting, 1);
        irq_en = 1'b1;
    endtask

    task automatic t_overrun();
        sync();
        push(8'h10, 1'b0, 1'b0);
        push(8'h20, 1'b0, 1'b0);
        push(8'h30, 1'b0, 1'b0);
        push(8'h40, 1'b1, 1'b0);
        chk("R5 close", close_stb, 1);
        chk("R5 ov status", st_ov, 1);
        chk("R9 ov over parity", {st_cd, st_pr}, 0);
        chk("R11 irq", rx_irq, 1);
        chk("R5 level", fifo_level, 3);
        push(8'h77, 1'b0, 1'b0);   // offered during close
        chk("R10 close one cycle", close_stb, 0);
        chk("R10 hunt after close", hunting, 1);
        chk("R10 close-cycle byte ignored", fifo_level, 3);
        chk("R10 status held", st_ov, 1);
        drain("R5", 8'h10, 1'b0);
        drain("R5", 8'h20, 1'b0);
        drain("R5", 8'h40, 1'b1);
        chk("R5 drained", fifo_vld, 0);
    endtask

    task automatic t_parity();
        sync();
        push(8'h5A, 1'b1, 1'b0);
        chk("R8 close", close_stb, 1);
        chk("R8 pr status", st_pr, 1);
        chk("R8 byte kept", fifo_level, 1);
        chk("R11 irq", rx_irq, 1);
        push(8'h66, 1'b0, 1'b0);
        chk("R10 hunt", hunting, 1);
        chk("R10 pr held", st_pr, 1);
        push(8'h67, 1'b0, 1'b0);
        chk("R2 hunt byte ignored", fifo_level, 1);
        drain("R8", 8'h5A, 1'b1);
    endtask

    task automatic t_prio_full();
        sync();
        push(8'hC1, 1'b0, 1'b0);
        push(8'hC2, 1'b0, 1'b0);
        push(8'hC3, 1'b0, 1'b0);
        carrier_ok = 1'b0;
        push(8'hC4, 1'b1, 1'b0);
        carrier_ok = 1'b1;
        chk("R9 only cd", {st_cd, st_ov, st_pr}, 3'b100);
        chk("R9 flushed", fifo_level, 0);
        step();
    endtask

    task automatic t_swctl();
        carrier_ok = 1'b0;
        cd_sw_ctl  = 1'b1;
        sync();
        push(8'hD1, 1'b0, 1'b0);
        chk("R7 byte accepted", fifo_level, 1);
        chk("R7 no close", close_stb, 0);
        chk("R7 still receiving", hunting, 0);
        cd_sw_ctl = 1'b0;
        step();
        chk("R6 cd close after control returns", {close_stb, st_cd}, 2'b11);
        chk("R6 flushed", fifo_level, 0);
        carrier_ok = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_hunt();
        t_order();
        t_cd();
        t_overrun();
        t_parity();
        t_prio_full();
        t_swctl();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule